// File: doc/BRIEF.md
# Multi-Mode Acquisition Trigger Sequencer

This block decides, sample by sample, whether an incoming converter sample is pushed into the capture FIFO. It is armed by an enable level and follows one of five capture disciplines. Immediate capture needs no event. Post capture stores samples only after the trigger. Pre capture keeps the FIFO circulating until the trigger and then freezes it. Middle capture does the same, then keeps a bounded tail after the trigger. Delayed capture waits a counted number of sampling ticks after the trigger, then stores a bounded burst. Trigger detection, clock division and transfer of the stored data to the host are done elsewhere.

The same preloaded down counter supplies the post-trigger sample budget, the length of the delay and the length of the middle-mode tail. A status output reports when that counter has run out. A separate sticky flag reports a capture that was cut short by a full FIFO. A single-cycle pulse marks the end of every run. After the run ends the sequencer holds until the enable is dropped.

Top module: `acq_trig_seq`

## Requirements
- R1: After reset, and while `acq_en_i` is low, `wr_en_o`, `acquiring_o`, `done_o`, `cnt_done_o` and `overrun_o` are all 0.
- R2: Mode code 0 (and unused codes 5, 6, 7) is immediate capture. Writes start the cycle after `acq_en_i` is first seen high, with no trigger needed. Exactly max(`post_cnt_i`,1) samples are written, one per `smp_tick_i`.
- R3: Mode code 1 is post capture. A trigger seen while idle is ignored. Nothing is written before the trigger. After it, exactly max(`post_cnt_i`,1) samples are written, one per tick. The count is sampled in the trigger cycle.
- R4: Mode code 2 is pre capture. While waiting, every tick is written, including the tick in the trigger cycle, and `fifo_full_i` is ignored. The trigger ends the run with no further writes, and `cnt_done_o` stays 0.
- R5: Mode code 3 is middle capture. Samples are written on every tick before the trigger, as in R4. After the trigger, exactly max(`post_cnt_i`,1) more are written. `fifo_full_i` is ignored throughout.
- R6: Mode code 4 is delayed capture. After the trigger, exactly `post_cnt_i` ticks pass with no write, then max(`post_cnt_i`,1) samples are written. A count of 0 means no delay and one sample.
- R7: A count of 0 in immediate, post or middle mode yields exactly one stored sample after the start point.
- R8: `acquiring_o` is 1 only in the bounded capture phase. It is 0 while idle, while waiting for the trigger (even when pre-filling), during the delay, and after the end.
- R9: In modes 0, 1 and 4, `fifo_full_i` high during the capture phase blocks the write, ends the run and sets the sticky `overrun_o`.
- R10: `done_o` is high for exactly one cycle when a run ends. The sequencer then writes nothing until re-armed. `cnt_done_o` is set when the counter expires (end of the budget, or end of the delay). Both sticky flags clear on the first clock edge with `acq_en_i` low.
- R11: Lowering `acq_en_i` blocks writes in that same cycle and returns the sequencer to idle at the next edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_en_i | input | 1 | Arm level; low aborts and clears |
| mode_i | input | 3 | Capture mode code |
| post_cnt_i | input | CNT_W | Budget / delay preload |
| trig_i | input | 1 | Trigger event, one cycle |
| smp_tick_i | input | 1 | Sampling clock enable |
| fifo_full_i | input | 1 | Capture FIFO full |
| wr_en_o | output | 1 | Push current sample into FIFO |
| acquiring_o | output | 1 | Bounded capture phase active |
| cnt_done_o | output | 1 | Counter expired (sticky) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| overrun_o | output | 1 | Capture cut by full FIFO (sticky) |

## Verification
The bench builds the sequencer with an 8-bit counter, so budgets and delays from 0 up to a few dozen ticks finish in short runs while the zero-preload corner stays in reach. Sparse random tick patterns separate counted ticks from clock cycles. With them the bench can check that delay length and burst length follow the ticks and not the cycles. Forcing the FIFO full mid-burst, and holding it full during pre and middle runs, covers both the abort path and the path where full is ignored.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_SOFT  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_POST  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PRE   = 3'd2;
  localparam logic [MODE_W-1:0] MODE_MID   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DELAY = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DELAY = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic need_trig;     // wait for an event before the bounded phase
    logic pre_fill;      // write while waiting
    logic stop_at_trig;  // event ends the run
    logic use_delay;     // event starts a counted delay
    logic stop_on_full;  // full FIFO aborts capture
  } mode_cfg_t;
endpackage

// File: rtl/acq_mode_dec.sv
module acq_mode_dec
  import acq_seq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_cfg_t         cfg_o
);
  always_comb begin
    cfg_o = '{need_trig: 1'b0, pre_fill: 1'b0, stop_at_trig: 1'b0,
              use_delay: 1'b0, stop_on_full: 1'b1};
    case (mode_i)
      MODE_POST:  cfg_o.need_trig = 1'b1;
      MODE_PRE: begin
        cfg_o.need_trig    = 1'b1;
        cfg_o.pre_fill     = 1'b1;
        cfg_o.stop_at_trig = 1'b1;
        cfg_o.stop_on_full = 1'b0;
      end
      MODE_MID: begin
        cfg_o.need_trig    = 1'b1;
        cfg_o.pre_fill     = 1'b1;
        cfg_o.stop_on_full = 1'b0;
      end
      MODE_DELAY: begin
        cfg_o.need_trig = 1'b1;
        cfg_o.use_delay = 1'b1;
      end
      default: ;  // immediate capture
    endcase
  end
endmodule

// File: rtl/acq_budget_cnt.sv
module acq_budget_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign last_o   = (cnt_q == ONE);
  assign expire_o = dec_i & last_o;
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_en_i,
  input  mode_cfg_t        cfg_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             trig_i,
  input  logic             smp_tick_i,
  input  logic             fifo_full_i,
  input  logic             cnt_last_i,
  input  logic             cnt_expire_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_load_val_o,
  output logic             cnt_dec_o,
  output logic             wr_en_o,
  output logic             acquiring_o,
  output logic             cnt_done_o,
  output logic             done_o,
  output logic             overrun_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic             ovr_set;
  logic [CNT_W-1:0] budget;

  assign budget = (post_cnt_i == '0) ? ONE : post_cnt_i;

  always_comb begin
    st_d           = st_q;
    cnt_load_o     = 1'b0;
    cnt_load_val_o = budget;
    cnt_dec_o      = 1'b0;
    wr_en_o        = 1'b0;
    ovr_set        = 1'b0;
    if (!acq_en_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_load_o = 1'b1;
          st_d       = cfg_i.need_trig ? ST_WAIT : ST_CAPT;
        end
        ST_WAIT: begin
          wr_en_o = cfg_i.pre_fill & smp_tick_i;
          if (trig_i) begin
            if (cfg_i.stop_at_trig) begin
              st_d = ST_DONE;
            end else if (cfg_i.use_delay && post_cnt_i != '0) begin
              cnt_load_o     = 1'b1;
              cnt_load_val_o = post_cnt_i;
              st_d           = ST_DELAY;
            end else begin
              cnt_load_o = 1'b1;
              st_d       = ST_CAPT;
            end
          end
        end
        ST_DELAY: begin
          if (smp_tick_i) begin
            cnt_dec_o = 1'b1;
            if (cnt_last_i) begin
              cnt_load_o = 1'b1;  // reload burst length
              st_d       = ST_CAPT;
            end
          end
        end
        ST_CAPT: begin
          if (cfg_i.stop_on_full && fifo_full_i) begin
            ovr_set = 1'b1;
            st_d    = ST_DONE;
          end else if (smp_tick_i) begin
            wr_en_o   = 1'b1;
            cnt_dec_o = 1'b1;
            if (cnt_last_i) st_d = ST_DONE;
          end
        end
        ST_DONE: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      done_o     <= 1'b0;
      overrun_o  <= 1'b0;
      cnt_done_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      done_o     <= (st_d == ST_DONE) && (st_q != ST_DONE);
      overrun_o  <= acq_en_i & (overrun_o | ovr_set);
      cnt_done_o <= acq_en_i & (cnt_done_o | cnt_expire_i);
    end
  end

  assign acquiring_o = (st_q == ST_CAPT);
endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_en_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  input  logic             trig_i,
  input  logic             smp_tick_i,
  input  logic             fifo_full_i,
  output logic             wr_en_o,
  output logic             acquiring_o,
  output logic             cnt_done_o,
  output logic             done_o,
  output logic             overrun_o
);
  mode_cfg_t        cfg;
  logic             cnt_load, cnt_dec, cnt_last, cnt_expire;
  logic [CNT_W-1:0] cnt_load_val;

  acq_mode_dec u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  acq_budget_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last),
    .expire_o   (cnt_expire)
  );

  acq_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acq_en_i       (acq_en_i),
    .cfg_i          (cfg),
    .post_cnt_i     (post_cnt_i),
    .trig_i         (trig_i),
    .smp_tick_i     (smp_tick_i),
    .fifo_full_i    (fifo_full_i),
    .cnt_last_i     (cnt_last),
    .cnt_expire_i   (cnt_expire),
    .cnt_load_o     (cnt_load),
    .cnt_load_val_o (cnt_load_val),
    .cnt_dec_o      (cnt_dec),
    .wr_en_o        (wr_en_o),
    .acquiring_o    (acquiring_o),
    .cnt_done_o     (cnt_done_o),
    .done_o         (done_o),
    .overrun_o      (overrun_o)
  );
endmodule

// File: rtl/acq_trig_seq_chk.sv
module acq_trig_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acq_en_i,
  input logic [2:0] mode_i,
  input logic       smp_tick_i,
  input logic       fifo_full_i,
  input logic       wr_en_o,
  input logic       acquiring_o,
  input logic       cnt_done_o,
  input logic       done_o,
  input logic       overrun_o
);
  a_r11_no_write_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_en_i |-> !wr_en_o);

  a_r11_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_en_i |=> (!acquiring_o && !overrun_o && !cnt_done_o));

  a_r3_write_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> smp_tick_i);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_en_o && !acquiring_o));

  a_r9_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acquiring_o && fifo_full_i && mode_i != 3'd2 && mode_i != 3'd3) |-> !wr_en_o);

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && acq_en_i) |=> overrun_o);

  a_r10_cnt_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_done_o && acq_en_i) |=> cnt_done_o);
endmodule

bind acq_trig_seq acq_trig_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acq_en_i    (acq_en_i),
  .mode_i      (mode_i),
  .smp_tick_i  (smp_tick_i),
  .fifo_full_i (fifo_full_i),
  .wr_en_o     (wr_en_o),
  .acquiring_o (acquiring_o),
  .cnt_done_o  (cnt_done_o),
  .done_o      (done_o),
  .overrun_o   (overrun_o)
);

// File: tb/acq_trig_seq_tb.sv
`timescale 1ns/1ps
module acq_trig_seq_tb;
  localparam int CNT_W = 8;
  localparam int MAXC  = 600;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [2:0]       mode = '0;
  logic [CNT_W-1:0] pcnt = '0;
  logic             trig = 1'b0, tick = 1'b0, full = 1'b0;
  logic             wr, acq, cdone, done, ovr;

  int n_tests = 0, n_fail = 0;
  int g_pre, g_post, g_tpre, g_gap, g_done, g_acq;
  bit g_ovr, g_cdone, g_hold_ok, g_clr_ok, g_fin;

  always #2.5 clk = ~clk;

  acq_trig_seq #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acq_en_i(en), .mode_i(mode),
    .post_cnt_i(pcnt), .trig_i(trig), .smp_tick_i(tick), .fifo_full_i(full),
    .wr_en_o(wr), .acquiring_o(acq), .cnt_done_o(cdone), .done_o(done),
    .overrun_o(ovr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int budget(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  function automatic int exp_total(input int m, input int b, input int tpre);
    int t;
    t = (m == 2 || m == 3) ? tpre : 0;
    if (m != 2) t += budget(b);
    return t;
  endfunction

  // one run: T<0 means no trigger; F<0 means FIFO never full
  task automatic run(input int m, input int b, input int T, input int pct,
                     input int F, input bit early_trig);
    bit first;
    g_pre = 0; g_post = 0; g_tpre = 0; g_gap = 0; g_done = 0; g_acq = 0;
    g_ovr = 0; g_cdone = 0; g_fin = 0; first = 0;
    mode = 3'(m); pcnt = CNT_W'(b);
    for (int c = 0; c < MAXC; c++) begin
      en   = 1'b1;
      trig = (c == T) || (early_trig && c == 0);
      tick = ($urandom_range(99) < pct);
      full = (F >= 0 && c >= F);
      @(negedge clk);
      if (done) begin g_done++; g_ovr = ovr; g_cdone = cdone; end
      if (acq) g_acq++;
      if (T >= 0 && c <= T) begin
        if (wr) g_pre++;
        if (tick && c >= 1) g_tpre++;
      end else begin
        if (wr) begin g_post++; first = 1; end
        else if (tick && !first && T >= 0 && c > T) g_gap++;
      end
      @(posedge clk); #1;
      if (g_done != 0) begin g_fin = 1; break; end
    end
    trig = 0; tick = 1; full = 0;
    @(negedge clk);
    g_hold_ok = !wr && !acq && !done;
    @(posedge clk); #1;
    en = 0;
    @(negedge clk);
    @(posedge clk); #1;
    @(negedge clk);
    g_clr_ok = !ovr && !cdone && !acq && !wr;
    @(posedge clk); #1;
    tick = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    #12; rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(!wr && !acq && !done && !cdone && !ovr, "R1 reset outputs",
        {wr, acq, done, cdone, ovr}, 0);
    @(posedge clk); #1;
    // trigger and ticks while disabled: nothing happens
    trig = 1; tick = 1; full = 1; mode = 3'd2;
    @(negedge clk);
    chk(!wr && !acq, "R1 idle ignores inputs", {wr, acq}, 0);
    @(posedge clk); #1; trig = 0; tick = 0; full = 0;

    run(0, 5, -1, 60, -1, 0);
    chk(g_fin && g_post == 5, "R2 software budget", g_post, 5);
    chk(g_cdone && g_done == 1 && g_hold_ok && g_clr_ok, "R10 soft end/clear",
        {g_cdone, g_hold_ok, g_clr_ok}, 7);

    run(5, 3, -1, 100, -1, 0);
    chk(g_post == 3 && g_acq == 3, "R2 unused code acts as software", g_post, 3);

    run(1, 7, 6, 50, -1, 1);
    chk(g_pre == 0, "R3 no write before trigger", g_pre, 0);
    chk(g_post == 7, "R3 post budget", g_post, 7);
    chk(g_cdone && !g_ovr && g_done == 1, "R10 post flags", {g_cdone, g_ovr}, 2);

    run(1, 0, 3, 70, -1, 0);
    chk(g_post == 1, "R7 post zero preload", g_post, 1);

    run(2, 9, 20, 50, 3, 0);
    chk(g_pre == g_tpre && g_tpre > 0, "R4 pre writes every tick", g_pre, g_tpre);
    chk(g_post == 0 && !g_cdone && !g_ovr, "R4 stop at trigger", g_post, 0);
    chk(g_acq == 0, "R8 acquiring low while pre-filling", g_acq, 0);

    run(3, 4, 10, 60, 2, 0);
    chk(g_pre == g_tpre, "R5 middle pre part", g_pre, g_tpre);
    chk(g_post == 4 && !g_ovr, "R5 middle tail ignores full", g_post, 4);

    run(3, 0, 5, 80, -1, 0);
    chk(g_post == 1, "R7 middle zero preload", g_post, 1);

    run(4, 5, 4, 40, -1, 0);
    chk(g_pre == 0 && g_gap == 5, "R6 delay length in ticks", g_gap, 5);
    chk(g_post == 5 && g_cdone, "R6 delayed burst", g_post, 5);

    run(4, 0, 2, 50, -1, 0);
    chk(g_gap == 0 && g_post == 1, "R6 zero delay one sample", g_post, 1);

    run(1, 20, 2, 100, 10, 0);
    chk(g_post == 7, "R9 full stops capture", g_post, 7);
    chk(g_ovr && !g_cdone && g_clr_ok, "R9 overrun sticky then cleared",
        {g_ovr, g_cdone}, 2);

    run(4, 3, 2, 100, 7, 0);
    chk(g_ovr && g_post == 1, "R9 full in delayed burst", g_post, 1);

    run(1, 6, 3, 100, -1, 0);
    chk(g_acq == 6, "R8 acquiring only in capture", g_acq, 6);

    run(4, 4, 1, 100, -1, 0);
    chk(g_acq == 4, "R8 acquiring low during delay", g_acq, 4);

    // abort mid-capture
    mode = 3'd0; pcnt = 8'd50; tick = 1; en = 1;
    for (int c = 0; c < 4; c++) begin @(posedge clk); #1; end
    en = 0;
    @(negedge clk);
    chk(!wr, "R11 write blocked same cycle", wr, 0);
    @(posedge clk); #1;
    en = 1; mode = 3'd1;  // re-armed in post mode: must wait for trigger
    @(negedge clk);
    chk(!acq && !wr, "R11 back to idle", {acq, wr}, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(!acq && !wr, "R11 re-armed waits for trigger", {acq, wr}, 0);
    @(posedge clk); #1; en = 0; tick = 0;
    @(posedge clk); #1;

    for (int i = 0; i < 10; i++) begin
      int m, b, t, p;
      m = $urandom_range(4); b = $urandom_range(20);
      t = 1 + $urandom_range(14); p = 30 + $urandom_range(70);
      run(m, b, t, p, -1, 0);
      chk(g_pre + g_post == exp_total(m, b, g_tpre), "R2 R3 R4 R5 R6 random total",
          g_pre + g_post, exp_total(m, b, g_tpre));
      chk(g_done == 1 && g_cdone == (m != 2), "R10 random end flags",
          {g_done, g_cdone}, {1, m != 2});
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule